// File: doc/BRIEF.md
# Page-Write Timing Controller for a Parallel EEPROM

This block is the device-side write control of a page-mode parallel EEPROM. It runs on a fast sampling clock and watches the active-low chip-enable, write-enable and output-enable pins. A write strobe counts only when chip-enable is low and output-enable is high, and only if it stays low for a minimum number of samples. On the rising edge of a qualified strobe, the address and data present in that sample are captured into a page buffer.

Each qualified rising edge restarts a byte-load window. While write-enable stays high the window counts down. A new falling edge freezes it, so the next byte joins the same page. When the window runs out, programming begins. The captured page is offered on a valid/ready output, and the active-low ready/busy pin is held low for the programming time. Write strobes are ignored for a settling period after reset and for the whole programming phase. All durations are parameters in sampling-clock cycles.

Back-pressure rule: `commit_valid` rises in the cycle programming begins. Page address, data and byte mask then hold steady until the cycle in which `commit_ready` is high. The programming phase ends only after it has lasted its full time and the page has been accepted. If the consumer stalls, ready/busy stays low for longer.

Top module: `eeprom_page_ctrl`

## Requirements
- R1: After reset, `rdy_busy_n` is high and `commit_valid` is low, and every write strobe is ignored for the first INIT_CYC cycles.
- R2: A write strobe counts only in samples where `ce_n` is 0 and `oe_n` is 1; a low `we_n` under any other pin state loads nothing.
- R3: A strobe with fewer than MIN_LOW_CYC consecutive qualified low samples loads no byte and does not pull `rdy_busy_n` low.
- R4: On a qualified rising edge, `din` is stored at byte offset `addr[log2(PAGE_BYTES)-1:0]`, that offset's mask bit is set, and the page address becomes the upper address bits of that byte, so the last byte loaded wins.
- R5: Every qualified rising edge restarts the byte-load timer. If `we_n` stays high, `commit_valid` becomes visible BLC_CYC+1 samples after the sample in which `we_n` was seen high.
- R6: A qualified falling edge before expiry freezes the timer for as long as the strobe is low, however long that is, and the following byte joins the same page.
- R7: `rdy_busy_n` goes low once a qualified strobe has been low for MIN_LOW_CYC samples, and it stays low through byte loading.
- R8: `commit_valid` rises as programming starts, with a non-empty mask. While `commit_valid` is high and `commit_ready` is low, `commit_page`, `commit_data` and `commit_mask` are stable. `commit_valid` falls after the accepting cycle.
- R9: `rdy_busy_n` stays low for exactly PROG_CYC cycles from the start of programming when the page is accepted at once, stays low until acceptance otherwise, and then returns high with the byte mask cleared.
- R10: A write strobe whose rising edge falls inside the programming phase loads nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| rdy_busy_n | output | 1 | Low while a write is loading or programming |
| commit_valid | output | 1 | Page ready for the cell array |
| commit_ready | input | 1 | Cell array accepts the page |
| commit_page | output | ADDR_W-log2(PAGE_BYTES) | Page address of the committed page |
| commit_data | output | PAGE_BYTES*DATA_W | Page contents, byte i at bits i*DATA_W |
| commit_mask | output | PAGE_BYTES | One bit per byte loaded in this page |

## Verification
The bench builds the block with a 6-bit address, 4-byte pages, a 2-sample strobe minimum, a 20-cycle settling period, a 40-cycle byte-load window and 30 cycles of programming. These scaled values let a short run cross the settling boundary, let the load window expire several times, and let a strobe be held low for longer than the whole window. They also leave room for a write to land inside programming and for a stalled consumer to hold the page well past the programming time.

// File: rtl/eeprom_pw_pkg.sv
package eeprom_pw_pkg;
  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_IDLE = 2'd1,
    ST_LOAD = 2'd2,
    ST_PROG = 2'd3
  } pw_state_e;
endpackage

// File: rtl/eeprom_we_filter.sv
// Qualifies the write strobe and measures its low width in samples.
module eeprom_we_filter #(
  parameter int MIN_LOW_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic qual_low,
  output logic armed,
  output logic rise,
  output logic load
);
  localparam int CW = $clog2(MIN_LOW_CYC + 1) + 1;

  logic [CW-1:0] low_cnt;

  assign qual_low = !ce_n && !we_n && oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (qual_low) begin
      if (low_cnt < CW'(MIN_LOW_CYC)) low_cnt <= low_cnt + 1'b1;
    end else begin
      low_cnt <= '0;
    end
  end

  assign armed = (low_cnt >= CW'(MIN_LOW_CYC));
  assign rise  = !qual_low && (low_cnt != '0);
  assign load  = rise && armed;
endmodule

// File: rtl/eeprom_page_buf.sv
// Page register file with per-byte load mask.
module eeprom_page_buf #(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         clr,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            din,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_addr,
  output logic [PAGE_BYTES*DATA_W-1:0] page_data,
  output logic [PAGE_BYTES-1:0]        page_mask
);
  localparam int OFS_W = $clog2(PAGE_BYTES);

  logic [OFS_W-1:0] ofs;
  assign ofs = addr[OFS_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page_addr <= '0;
    else if (wr_en) page_addr <= addr[ADDR_W-1:OFS_W];
  end

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        page_data[i*DATA_W +: DATA_W] <= '0;
        page_mask[i]                  <= 1'b0;
      end else if (wr_en && (ofs == OFS_W'(i))) begin
        page_data[i*DATA_W +: DATA_W] <= din;
        page_mask[i]                  <= 1'b1;
      end else if (clr) begin
        page_mask[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/eeprom_pw_seq.sv
// Sequencer: settling period, byte-load window, programming phase.
// One counter serves all three phases.
module eeprom_pw_seq
  import eeprom_pw_pkg::*;
#(
  parameter int INIT_CYC = 500_000,
  parameter int BLC_CYC  = 10_000_000,
  parameter int PROG_CYC = 500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic qual_low,
  input  logic armed,
  input  logic rise,
  input  logic load,
  input  logic commit_ready,
  output logic buf_wr,
  output logic buf_clr,
  output logic commit_valid,
  output logic rdy_busy_n
);
  localparam int MAX_AB = (INIT_CYC > BLC_CYC) ? INIT_CYC : BLC_CYC;
  localparam int MAX_C  = (MAX_AB > PROG_CYC) ? MAX_AB : PROG_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  pw_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic             prog_end;

  assign buf_wr   = load && ((state == ST_IDLE) || (state == ST_LOAD));
  assign prog_end = (state == ST_PROG) && (cnt == CNT_W'(PROG_CYC - 1)) &&
                    (!commit_valid || commit_ready);
  assign buf_clr  = prog_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_INIT;
      cnt          <= '0;
      commit_valid <= 1'b0;
    end else begin
      case (state)
        ST_INIT: begin
          if (cnt == CNT_W'(INIT_CYC - 1)) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_IDLE: begin
          if (buf_wr) begin
            state <= ST_LOAD;
            cnt   <= '0;
          end
        end
        ST_LOAD: begin
          if (rise) begin
            cnt <= '0;
          end else if (!qual_low) begin
            if (cnt == CNT_W'(BLC_CYC - 1)) begin
              state        <= ST_PROG;
              cnt          <= '0;
              commit_valid <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: begin
          if (commit_valid && commit_ready) commit_valid <= 1'b0;
          if (prog_end) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else if (cnt != CNT_W'(PROG_CYC - 1)) begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign rdy_busy_n = !((state == ST_LOAD) || (state == ST_PROG) ||
                        ((state == ST_IDLE) && armed));
endmodule

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl #(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 32,
  parameter int MIN_LOW_CYC = 2,
  parameter int INIT_CYC    = 500_000,
  parameter int BLC_CYC     = 10_000_000,
  parameter int PROG_CYC    = 500_000
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  ce_n,
  input  logic                                  oe_n,
  input  logic                                  we_n,
  input  logic [ADDR_W-1:0]                     addr,
  input  logic [DATA_W-1:0]                     din,
  output logic                                  rdy_busy_n,
  output logic                                  commit_valid,
  input  logic                                  commit_ready,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]  commit_page,
  output logic [PAGE_BYTES*DATA_W-1:0]          commit_data,
  output logic [PAGE_BYTES-1:0]                 commit_mask
);
  logic qual_low, armed, rise, load, buf_wr, buf_clr;

  eeprom_we_filter #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .qual_low(qual_low), .armed(armed), .rise(rise), .load(load)
  );

  eeprom_pw_seq #(
    .INIT_CYC(INIT_CYC), .BLC_CYC(BLC_CYC), .PROG_CYC(PROG_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .qual_low(qual_low), .armed(armed),
    .rise(rise), .load(load), .commit_ready(commit_ready),
    .buf_wr(buf_wr), .buf_clr(buf_clr), .commit_valid(commit_valid),
    .rdy_busy_n(rdy_busy_n)
  );

  eeprom_page_buf #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)
  ) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(buf_wr), .clr(buf_clr),
    .addr(addr), .din(din), .page_addr(commit_page),
    .page_data(commit_data), .page_mask(commit_mask)
  );
endmodule

// File: rtl/eeprom_page_ctrl_chk.sv
module eeprom_page_ctrl_chk #(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32,
  parameter int INIT_CYC   = 500_000
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 rdy_busy_n,
  input logic                                 commit_valid,
  input logic                                 commit_ready,
  input logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] commit_page,
  input logic [PAGE_BYTES*DATA_W-1:0]         commit_data,
  input logic [PAGE_BYTES-1:0]                commit_mask
);
  localparam int SW = $clog2(INIT_CYC + 1) + 1;
  logic [SW-1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst < SW'(INIT_CYC)) since_rst <= since_rst + 1'b1;
  end

  // R1: quiet during the settling period
  a_r1_init_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < SW'(INIT_CYC)) |-> (rdy_busy_n && !commit_valid));

  // R8: offered page held while stalled
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && !commit_ready) |=>
      (commit_valid && $stable(commit_page) && $stable(commit_data) && $stable(commit_mask)));

  // R8: a commit never carries an empty page
  a_r8_mask_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(commit_valid) |-> (commit_mask != '0));

  // R9: busy while a page is offered
  a_r9_busy_with_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> !rdy_busy_n);

  // R9: release only after acceptance
  a_r9_release_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_busy_n) |-> !commit_valid);
endmodule

bind eeprom_page_ctrl eeprom_page_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES), .INIT_CYC(INIT_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rdy_busy_n(rdy_busy_n), .commit_valid(commit_valid),
  .commit_ready(commit_ready), .commit_page(commit_page),
  .commit_data(commit_data), .commit_mask(commit_mask)
);

// File: tb/eeprom_page_ctrl_tb.sv
module eeprom_page_ctrl_tb;
  localparam int AW = 6, DW = 8, PB = 4, MINL = 2, INIT = 20, BLC = 40, PROG = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0, ce_n = 1'b0, oe_n = 1'b1, we_n = 1'b1, ready_en = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic rdy_busy_n, commit_valid;
  logic [3:0] commit_page;
  logic [PB*DW-1:0] commit_data;
  logic [PB-1:0] commit_mask;

  typedef struct { logic [3:0] page; logic [31:0] data; logic [3:0] mask; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  eeprom_page_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .MIN_LOW_CYC(MINL),
    .INIT_CYC(INIT), .BLC_CYC(BLC), .PROG_CYC(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
    .din(din), .rdy_busy_n(rdy_busy_n), .commit_valid(commit_valid),
    .commit_ready(ready_en), .commit_page(commit_page), .commit_data(commit_data),
    .commit_mask(commit_mask));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input int lowc,
                    input logic ce, input logic oe);
    @(negedge clk);
    addr = a; din = d; ce_n = ce; oe_n = oe; we_n = 1'b0;
    repeat (lowc) @(negedge clk);
    we_n = 1'b1;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic push(input logic [3:0] pg, input logic [31:0] d, input logic [3:0] m);
    exp_t e;
    e.page = pg; e.data = d; e.mask = m;
    q.push_back(e);
  endtask

  task automatic wait_idle();
    int n = 0;
    #2;
    while (!rdy_busy_n && n < 1000) begin
      @(negedge clk); #2; n++;
    end
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(negedge clk); #3;
      if (rst_n && commit_valid && ready_en) begin
        if (q.size() == 0) begin
          chk(1'b0, "R3/R10 unexpected commit", {28'd0, commit_mask}, 0);
        end else begin
          exp_t e;
          logic [31:0] bm;
          e = q.pop_front();
          for (int i = 0; i < PB; i++) bm[i*8 +: 8] = {8{e.mask[i]}};
          chk(commit_mask == e.mask, "R9 commit mask", {28'd0, commit_mask}, {28'd0, e.mask});
          chk(commit_page == e.page, "R4 commit page", {28'd0, commit_page}, {28'd0, e.page});
          chk((commit_data & bm) == e.data, "R4 commit data", commit_data & bm, e.data);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(rdy_busy_n == 1'b1, "R1 reset busy", rdy_busy_n, 1);
    chk(commit_valid == 1'b0, "R1 reset valid", commit_valid, 0);

    // R1: valid strobe inside the settling period is ignored
    wr(6'h05, 8'hAA, 3, 1'b0, 1'b1);
    #2 chk(rdy_busy_n == 1'b1, "R1 init write", rdy_busy_n, 1);
    gap(BLC + 20);
    chk(rdy_busy_n == 1'b1, "R1 init no load", rdy_busy_n, 1);

    // R3: glitch strobe
    wr(6'h04, 8'h55, 1, 1'b0, 1'b1);
    #2 chk(rdy_busy_n == 1'b1, "R3 glitch busy", rdy_busy_n, 1);
    gap(BLC + 5);
    chk(rdy_busy_n == 1'b1, "R3 glitch no load", rdy_busy_n, 1);

    // R2: output-enable low, then chip-enable high
    wr(6'h04, 8'h66, 4, 1'b0, 1'b0);
    #2 chk(rdy_busy_n == 1'b1, "R2 oe low", rdy_busy_n, 1);
    wr(6'h04, 8'h67, 4, 1'b1, 1'b1);
    #2 chk(rdy_busy_n == 1'b1, "R2 ce high", rdy_busy_n, 1);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1;
    gap(BLC + 5);
    chk(rdy_busy_n == 1'b1, "R2 no load", rdy_busy_n, 1);

    // R4/R5/R7/R9: three bytes into page 2
    push(4'd2, 32'hA3_00_A1_A0, 4'b1011);
    wr(6'd8, 8'hA0, 3, 1'b0, 1'b1);
    #2 chk(rdy_busy_n == 1'b0, "R7 busy after load", rdy_busy_n, 0);
    gap(5);
    chk(rdy_busy_n == 1'b0, "R7 busy in gap", rdy_busy_n, 0);
    wr(6'd9, 8'hA1, 3, 1'b0, 1'b1);
    gap(5);
    wr(6'd11, 8'hA3, 3, 1'b0, 1'b1);
    gap(BLC);
    chk(commit_valid == 1'b0, "R5 before expiry", commit_valid, 0);
    gap(1);
    chk(commit_valid == 1'b1, "R5 at expiry", commit_valid, 1);
    n = 0;
    while (!rdy_busy_n && n < 500) begin
      @(negedge clk); #2; n++;
    end
    chk(n == PROG, "R9 programming length", n, PROG);

    // R6: strobe held low longer than the window
    push(4'd5, 32'hB2_00_B0_00 >> 8, 4'b0101);
    wr(6'd20, 8'hB0, 3, 1'b0, 1'b1);
    gap(10);
    addr = 6'd22; din = 8'hB2; we_n = 1'b0;
    gap(BLC + 10);
    chk(commit_valid == 1'b0, "R6 timer frozen", commit_valid, 0);
    we_n = 1'b1;
    gap(BLC);
    chk(commit_valid == 1'b0, "R6 restart before expiry", commit_valid, 0);
    gap(1);
    chk(commit_valid == 1'b1, "R6 expiry", commit_valid, 1);
    wait_idle();

    // R8/R9/R10: stalled consumer, write during programming
    ready_en = 1'b0;
    push(4'd7, 32'h0000_C100, 4'b0010);
    wr(6'd29, 8'hC1, 3, 1'b0, 1'b1);
    gap(BLC + 1);
    chk(commit_valid == 1'b1, "R8 offered", commit_valid, 1);
    wr(6'd30, 8'hEE, 3, 1'b0, 1'b1);
    gap(PROG + 10);
    chk(commit_valid == 1'b1, "R8 held while stalled", commit_valid, 1);
    chk(rdy_busy_n == 1'b0, "R9 busy while stalled", rdy_busy_n, 0);
    ready_en = 1'b1;
    gap(1);
    chk(rdy_busy_n == 1'b1, "R9 release after accept", rdy_busy_n, 1);
    chk(commit_valid == 1'b0, "R8 valid drops", commit_valid, 0);
    gap(BLC + 10);
    chk(rdy_busy_n == 1'b1, "R10 no load in programming", rdy_busy_n, 1);

    // R9: mask cleared, next page has only its own byte
    push(4'd0, 32'h00D2_0000, 4'b0100);
    wr(6'd2, 8'hD2, 3, 1'b0, 1'b1);
    gap(BLC + 2);
    wait_idle();

    // R4: overwrite at one offset, page taken from the last byte
    push(4'd3, 32'h0033_0022, 4'b0101);
    wr(6'd4, 8'h11, 3, 1'b0, 1'b1);
    wr(6'd4, 8'h22, 3, 1'b0, 1'b1);
    wr(6'd14, 8'h33, 3, 1'b0, 1'b1);
    gap(BLC + 2);
    wait_idle();
    gap(2);
    chk(q.size() == 0, "R4 all pages committed", q.size(), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule